// File: doc/BRIEF.md
# Hot-Plug Slot Command Executor

This block takes 16-bit command words from a register interface and carries them out against a small bank of slot controllers and a bus speed/mode register. The low byte of a command is the opcode and the high byte names the target slot. Slots are numbered from 1, and the value 0 is used for bus-wide commands. One slot opcode carries three independent fields: slot state, power indicator and attention indicator. Each field has a code that leaves its target unchanged.

While a command runs, the busy flag is high and further command writes are dropped. At completion the block posts an error code next to the busy flag and latches a command-detected event in the interrupt/mask register. Software clears that event by writing 1 to it. The event raises `cmd_irq` unless it is masked. Each slot also has a timed power-good flag that stands in for a real power-up sequence.

Top module: `hp_cmd_exec`

## Requirements
- R1: The opcode is in `cmd_data[7:0]` and the target slot number is in `cmd_data[15:8]`, with slots numbered from 1. Opcodes 00h-3Fh are slot operations. Opcode bits 1:0 set the slot state (1 = power-only, 2 = enabled, 3 = disabled, 0 = no change). Slot k's state appears on `slot_state[2k+1:2k]`.
- R2: In a slot operation, opcode bits 3:2 set the power indicator and bits 5:4 set the attention indicator (1 = on, 2 = blink, 3 = off, 0 = no change). The indicators appear on `pwr_ind` and `attn_ind`, which use the same two-bits-per-slot layout as `slot_state`.
- R3: A command write is accepted only while `cmd_status[0]` (busy) is low. Busy then stays high for exactly BUSY_CYC cycles, starting in the cycle after the write. A command written while busy is ignored.
- R4: `cmd_status[2]` (invalid command) is set, and no state changes, in three cases: a slot operation addressed to slot 0, a slot operation addressed above NSLOT, or an opcode in 4Ah-4Fh or 60h-BFh.
- R5: `cmd_status[1]` (latch open) is set, and no slot state or indicator changes, in two cases. The first is a slot operation whose state field is 1 or 2 and whose target slot has `latch_open` high. The second is opcode 48h or 49h while any `latch_open` bit is high. A slot operation that disables a slot is not blocked by an open latch.
- R6: Opcodes 40h-44h set `bus_mode` to opcode bits 2:0. Opcodes 50h-5Dh set `bus_mode` to opcode bits 3:0. Opcodes 45h-47h and 5Eh-5Fh set `cmd_status[3]` (invalid speed/mode) and leave `bus_mode` unchanged.
- R7: Opcode 48h puts every slot in power-only and opcode 49h enables every slot. Neither changes any indicator.
- R8: Opcodes C0h-FFh complete with no error and change no state.
- R9: Every completed command sets `ctl_rdata[16]` (command detected), including commands that end in error. Writing `ctl_wdata[16]`=1 clears the bit. When a completion and a clear fall in the same cycle, the bit stays set. The error bits `cmd_status[3:1]` clear when the next command is accepted.
- R10: A write to the control register loads its mask bits 3:0 from `ctl_wdata[3:0]`: bit 0 is the global interrupt mask, bit 1 the global error mask, bit 2 the command interrupt mask and bit 3 the arbiter error mask. All four reset to 1. Bits 15:4 and 31:17 of `ctl_rdata` always read 0.
- R11: `cmd_irq` is high exactly when the command-detected bit is set and both mask bit 2 and mask bit 0 are clear.
- R12: `slot_pgood[k]` rises PWR_DLY cycles after slot k leaves the disabled state. It falls in the cycle after the slot returns to disabled.
- R13: After reset, all slots are disabled, all indicators are off, `bus_mode` is 0, `cmd_status` is 0, the command-detected bit is 0 and `slot_pgood` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 16 | Command word: slot number in 15:8, opcode in 7:0 |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control write data: masks in 3:0, clear of the command-detected bit in 16 |
| latch_open | input | NSLOT | Retention latch open, one bit per slot |
| cmd_status | output | 4 | {invalid speed/mode, invalid command, latch open, busy} |
| ctl_rdata | output | 32 | Control register value |
| cmd_irq | output | 1 | Command-complete interrupt |
| slot_state | output | 2*NSLOT | Slot states |
| pwr_ind | output | 2*NSLOT | Power indicator states |
| attn_ind | output | 2*NSLOT | Attention indicator states |
| slot_pgood | output | NSLOT | Power-good flag per slot after the power-up delay |
| bus_mode | output | 4 | Selected bus speed/mode code |

## Verification
The command-completion edge sets the command-detected bit. Software's write-one-to-clear of that same bit can arrive in the same clock cycle. The bench provokes this by counting BUSY_CYC cycles from the accepted command and placing the control write exactly on the completion edge. It then judges that the bit reads 1 afterwards, and that a later clear on its own returns the bit to 0. A second collision is a command write that arrives while a command is running. The bench judges it through the slot outputs, which must not show the dropped command.

// File: rtl/hp_cmd_pkg.sv
package hp_cmd_pkg;

  typedef enum logic [2:0] {
    OP_SLOT, OP_MODE_A, OP_MODE_B, OP_ALL_PWR,
    OP_ALL_EN, OP_BAD_SPEED, OP_BAD_CMD, OP_VENDOR
  } op_kind_e;

  localparam logic [1:0] FLD_KEEP    = 2'd0;
  localparam logic [1:0] ST_PWRONLY  = 2'd1;
  localparam logic [1:0] ST_ENABLED  = 2'd2;
  localparam logic [1:0] ST_DISABLED = 2'd3;
  localparam logic [1:0] IND_OFF     = 2'd3;

  // bit positions inside the 3-bit error code
  localparam int ERR_LATCH = 0;
  localparam int ERR_CMD   = 1;
  localparam int ERR_SPEED = 2;

  // opcode class by range
  function automatic op_kind_e classify(input logic [7:0] op);
    if (op < 8'h40)       return OP_SLOT;
    else if (op < 8'h45)  return OP_MODE_A;
    else if (op < 8'h48)  return OP_BAD_SPEED;
    else if (op == 8'h48) return OP_ALL_PWR;
    else if (op == 8'h49) return OP_ALL_EN;
    else if (op < 8'h50)  return OP_BAD_CMD;
    else if (op < 8'h5E)  return OP_MODE_B;
    else if (op < 8'h60)  return OP_BAD_SPEED;
    else if (op < 8'hC0)  return OP_BAD_CMD;
    else                  return OP_VENDOR;
  endfunction

  // mode code carried by a speed/mode opcode
  function automatic logic [3:0] mode_of(input logic [7:0] op);
    return (op[7:4] == 4'h4) ? {1'b0, op[2:0]} : op[3:0];
  endfunction

  // state field that needs a closed latch
  function automatic logic needs_latch(input logic [1:0] st);
    return (st == ST_PWRONLY) || (st == ST_ENABLED);
  endfunction

endpackage

// File: rtl/hp_cmd_decode.sv
module hp_cmd_decode
  import hp_cmd_pkg::*;
#(
  parameter int NSLOT = 4
) (
  input  logic [15:0]      cmd,
  input  logic [NSLOT-1:0] latch_open,
  output logic [2:0]       err,
  output logic [NSLOT-1:0] apply,
  output logic [1:0]       st_new,
  output logic [1:0]       pwr_new,
  output logic [1:0]       attn_new,
  output logic             mode_wr,
  output logic [3:0]       mode_val
);
  localparam logic [7:0] NS8 = 8'(NSLOT);

  logic [7:0]       op;
  logic [7:0]       tgt;
  logic             slot_ok;
  logic [NSLOT-1:0] sel;
  logic             latch_hit;
  op_kind_e         kind;

  assign op       = cmd[7:0];
  assign tgt      = cmd[15:8];
  assign slot_ok  = (tgt != 8'd0) && (tgt <= NS8);
  assign kind     = classify(op);
  assign mode_val = mode_of(op);

  always_comb begin
    for (int i = 0; i < NSLOT; i++) sel[i] = slot_ok && (tgt == 8'(i + 1));
  end
  assign latch_hit = |(sel & latch_open);

  always_comb begin
    err      = '0;
    apply    = '0;
    st_new   = FLD_KEEP;
    pwr_new  = FLD_KEEP;
    attn_new = FLD_KEEP;
    mode_wr  = 1'b0;
    unique case (kind)
      OP_SLOT: begin
        if (!slot_ok) err[ERR_CMD] = 1'b1;
        else if (needs_latch(op[1:0]) && latch_hit) err[ERR_LATCH] = 1'b1;
        else begin
          apply    = sel;
          st_new   = op[1:0];
          pwr_new  = op[3:2];
          attn_new = op[5:4];
        end
      end
      OP_ALL_PWR, OP_ALL_EN: begin
        if (|latch_open) err[ERR_LATCH] = 1'b1;
        else begin
          apply  = '1;
          st_new = (kind == OP_ALL_PWR) ? ST_PWRONLY : ST_ENABLED;
        end
      end
      OP_MODE_A, OP_MODE_B: mode_wr = 1'b1;
      OP_BAD_SPEED:         err[ERR_SPEED] = 1'b1;
      OP_BAD_CMD:           err[ERR_CMD] = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/hp_slot_unit.sv
module hp_slot_unit
  import hp_cmd_pkg::*;
#(
  parameter int PWR_DLY = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       apply,
  input  logic [1:0] st_new,
  input  logic [1:0] pwr_new,
  input  logic [1:0] attn_new,
  output logic [1:0] state,
  output logic [1:0] pwr,
  output logic [1:0] attn,
  output logic       pgood
);
  localparam int DW = $clog2(PWR_DLY + 1);

  logic [DW-1:0] dly_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_DISABLED;
      pwr   <= IND_OFF;
      attn  <= IND_OFF;
    end else if (apply) begin
      if (st_new   != FLD_KEEP) state <= st_new;
      if (pwr_new  != FLD_KEEP) pwr   <= pwr_new;
      if (attn_new != FLD_KEEP) attn  <= attn_new;
    end
  end

  // power-up delay: counts while the slot is out of the disabled state
  always_ff @(posedge clk) begin
    if (!rst_n || state == ST_DISABLED) begin
      dly_q <= '0;
      pgood <= 1'b0;
    end else if (!pgood) begin
      if (dly_q == DW'(PWR_DLY - 1)) pgood <= 1'b1;
      else dly_q <= dly_q + 1'b1;
    end
  end
endmodule

// File: rtl/hp_cmd_events.sv
module hp_cmd_events (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic [31:0] ctl_wdata,
  input  logic        cmd_done,
  output logic [31:0] ctl_rdata,
  output logic        cmd_irq
);
  logic [3:0] mask_q;
  logic       det_q;
  logic       unused_wdata;

  assign unused_wdata = ^{ctl_wdata[31:17], ctl_wdata[15:4]};

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= 4'hF;
    else if (ctl_wr) mask_q <= ctl_wdata[3:0];
  end

  // completion wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n) det_q <= 1'b0;
    else if (cmd_done) det_q <= 1'b1;
    else if (ctl_wr && ctl_wdata[16]) det_q <= 1'b0;
  end

  assign ctl_rdata = {15'd0, det_q, 12'd0, mask_q};
  assign cmd_irq   = det_q & ~mask_q[2] & ~mask_q[0];
endmodule

// File: rtl/hp_cmd_exec.sv
module hp_cmd_exec
  import hp_cmd_pkg::*;
#(
  parameter int NSLOT    = 4,
  parameter int BUSY_CYC = 4,
  parameter int PWR_DLY  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_wr,
  input  logic [15:0]        cmd_data,
  input  logic               ctl_wr,
  input  logic [31:0]        ctl_wdata,
  input  logic [NSLOT-1:0]   latch_open,
  output logic [3:0]         cmd_status,
  output logic [31:0]        ctl_rdata,
  output logic               cmd_irq,
  output logic [2*NSLOT-1:0] slot_state,
  output logic [2*NSLOT-1:0] pwr_ind,
  output logic [2*NSLOT-1:0] attn_ind,
  output logic [NSLOT-1:0]   slot_pgood,
  output logic [3:0]         bus_mode
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [15:0]   cmd_q;
  logic [2:0]    err_q;
  logic [3:0]    mode_q;

  // named internal events
  logic             cmd_accept;
  logic             cmd_done;
  logic [2:0]       dec_err;
  logic [NSLOT-1:0] dec_apply;
  logic [1:0]       dec_st, dec_pwr, dec_attn;
  logic             dec_mode_wr;
  logic [3:0]       dec_mode;

  assign cmd_accept = cmd_wr & ~busy_q;
  assign cmd_done   = busy_q & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cmd_q  <= '0;
      err_q  <= '0;
      mode_q <= '0;
    end else if (cmd_accept) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(BUSY_CYC - 1);
      cmd_q  <= cmd_data;
      err_q  <= '0;
    end else if (cmd_done) begin
      busy_q <= 1'b0;
      err_q  <= dec_err;
      if (dec_mode_wr) mode_q <= dec_mode;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  hp_cmd_decode #(.NSLOT(NSLOT)) u_dec (
    .cmd        (cmd_q),
    .latch_open (latch_open),
    .err        (dec_err),
    .apply      (dec_apply),
    .st_new     (dec_st),
    .pwr_new    (dec_pwr),
    .attn_new   (dec_attn),
    .mode_wr    (dec_mode_wr),
    .mode_val   (dec_mode)
  );

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    hp_slot_unit #(.PWR_DLY(PWR_DLY)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .apply    (cmd_done & dec_apply[k]),
      .st_new   (dec_st),
      .pwr_new  (dec_pwr),
      .attn_new (dec_attn),
      .state    (slot_state[2*k +: 2]),
      .pwr      (pwr_ind[2*k +: 2]),
      .attn     (attn_ind[2*k +: 2]),
      .pgood    (slot_pgood[k])
    );
  end

  hp_cmd_events u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .cmd_done  (cmd_done),
    .ctl_rdata (ctl_rdata),
    .cmd_irq   (cmd_irq)
  );

  assign cmd_status = {err_q, busy_q};
  assign bus_mode   = mode_q;
endmodule

// File: rtl/hp_cmd_exec_chk.sv
module hp_cmd_exec_chk #(
  parameter int NSLOT    = 4,
  parameter int BUSY_CYC = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_accept,
  input logic               cmd_done,
  input logic [3:0]         cmd_status,
  input logic [31:0]        ctl_rdata,
  input logic               cmd_irq,
  input logic [2*NSLOT-1:0] slot_state,
  input logic [NSLOT-1:0]   slot_pgood
);
  logic [15:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else if (cmd_status[0]) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> cmd_status[0]);

  a_r3_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 16'(BUSY_CYC));

  a_r9_err_clear_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_status[0] |-> cmd_status[3:1] == 3'b000);

  a_r9_det_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> ctl_rdata[16]);

  a_r4_single_error: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_status[3:1]));

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[31:17] == 15'd0 && ctl_rdata[15:4] == 12'd0);

  a_r11_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_irq |-> ctl_rdata[16] && !ctl_rdata[2] && !ctl_rdata[0]);

  a_r5_latch_reject: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_status[0]) && cmd_status[1] |-> slot_state == $past(slot_state));

  for (genvar k = 0; k < NSLOT; k++) begin : g_pg
    a_r12_pgood_drop: assert property (@(posedge clk) disable iff (!rst_n)
      slot_state[2*k +: 2] == 2'd3 |=> !slot_pgood[k]);
  end
endmodule

bind hp_cmd_exec hp_cmd_exec_chk #(.NSLOT(NSLOT), .BUSY_CYC(BUSY_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_accept (cmd_accept),
  .cmd_done   (cmd_done),
  .cmd_status (cmd_status),
  .ctl_rdata  (ctl_rdata),
  .cmd_irq    (cmd_irq),
  .slot_state (slot_state),
  .slot_pgood (slot_pgood)
);

// File: tb/hp_cmd_exec_test.sv
`timescale 1ns/1ps
module hp_cmd_exec_test;
  localparam int NS = 4;
  localparam int BC = 4;
  localparam int PD = 8;

  typedef struct {
    logic [3:0]    status;
    logic [2*NS-1:0] st;
    logic [2*NS-1:0] pw;
    logic [2*NS-1:0] at;
    logic [3:0]    mode;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic [15:0] cmd_data = '0;
  logic ctl_wr = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [NS-1:0] latch_open = '0;
  logic [3:0] cmd_status;
  logic [31:0] ctl_rdata;
  logic cmd_irq;
  logic [2*NS-1:0] slot_state, pwr_ind, attn_ind;
  logic [NS-1:0] slot_pgood;
  logic [3:0] bus_mode;

  int checks = 0;
  int errors = 0;
  exp_t sb[$];
  logic [1:0] m_st[NS];
  logic [1:0] m_pw[NS];
  logic [1:0] m_at[NS];
  logic [3:0] m_mode;

  always #2.5 clk = ~clk;

  hp_cmd_exec #(.NSLOT(NS), .BUSY_CYC(BC), .PWR_DLY(PD)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .latch_open(latch_open),
    .cmd_status(cmd_status), .ctl_rdata(ctl_rdata), .cmd_irq(cmd_irq),
    .slot_state(slot_state), .pwr_ind(pwr_ind), .attn_ind(attn_ind),
    .slot_pgood(slot_pgood), .bus_mode(bus_mode)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [2*NS-1:0] pack(input logic [1:0] a[NS]);
    logic [2*NS-1:0] v;
    for (int k = 0; k < NS; k++) v[2*k +: 2] = a[k];
    return v;
  endfunction

  // model of one command, written from the requirements
  task automatic model(input logic [7:0] op, input logic [7:0] tgt, output logic [2:0] er);
    er = 3'b000;
    if (op <= 8'h3F) begin
      if (tgt == 0 || tgt > NS) er = 3'b010;
      else if ((op[1:0] == 2'd1 || op[1:0] == 2'd2) && latch_open[tgt-1]) er = 3'b001;
      else begin
        if (op[1:0] != 0) m_st[tgt-1] = op[1:0];
        if (op[3:2] != 0) m_pw[tgt-1] = op[3:2];
        if (op[5:4] != 0) m_at[tgt-1] = op[5:4];
      end
    end else if (op <= 8'h44) m_mode = 4'(op - 8'h40);
    else if (op <= 8'h47) er = 3'b100;
    else if (op == 8'h48 || op == 8'h49) begin
      if (|latch_open) er = 3'b001;
      else for (int k = 0; k < NS; k++) m_st[k] = (op == 8'h48) ? 2'd1 : 2'd2;
    end else if (op <= 8'h4F) er = 3'b010;
    else if (op <= 8'h5D) m_mode = 4'(op - 8'h50);
    else if (op <= 8'h5F) er = 3'b100;
    else if (op < 8'hC0) er = 3'b010;
  endtask

  // driver: issue a command and push what it should produce
  task automatic issue(input logic [7:0] op, input logic [7:0] tgt, input string tag);
    exp_t e;
    logic [2:0] er;
    while (cmd_status[0]) @(negedge clk);
    cmd_data = {tgt, op};
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    model(op, tgt, er);
    e.status = {er, 1'b0};
    e.st = pack(m_st);
    e.pw = pack(m_pw);
    e.at = pack(m_at);
    e.mode = m_mode;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wait_idle();
    while (cmd_status[0]) @(negedge clk);
  endtask

  task automatic ctl_write(input logic [31:0] v);
    ctl_wdata = v;
    ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  // monitor: compare at each falling busy
  initial begin : mon
    logic pb;
    exp_t e;
    pb = 1'b0;
    forever begin
      @(negedge clk);
      if (pb && !cmd_status[0]) begin
        checks++;
        if (sb.size() == 0) begin
          errors++;
          $display("FAIL R3: unexpected completion, actual 1 expected 0");
        end else begin
          e = sb.pop_front();
          if (cmd_status !== e.status || slot_state !== e.st || pwr_ind !== e.pw ||
              attn_ind !== e.at || bus_mode !== e.mode) begin
            errors++;
            $display("FAIL %s: actual st=%h st=%h pw=%h at=%h m=%h expected st=%h st=%h pw=%h at=%h m=%h",
                     e.tag, cmd_status, slot_state, pwr_ind, attn_ind, bus_mode,
                     e.status, e.st, e.pw, e.at, e.mode);
          end
        end
      end
      pb = cmd_status[0];
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int n;
    for (int k = 0; k < NS; k++) begin m_st[k] = 2'd3; m_pw[k] = 2'd3; m_at[k] = 2'd3; end
    m_mode = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state, R10 mask reset
    check("R13 status", 32'(cmd_status), 32'h0);
    check("R13 state", 32'(slot_state), 32'hFF);
    check("R13 indicators", 32'({pwr_ind, attn_ind}), 32'hFFFF);
    check("R13 mode/pgood", 32'({bus_mode, slot_pgood}), 32'h0);
    check("R10 reset ctl", ctl_rdata, 32'h0000_000F);
    check("R11 reset irq", 32'(cmd_irq), 32'h0);

    // R1 power-only slot 1, R3 busy length
    issue(8'h01, 8'd1, "R1 power-only");
    n = 1;
    @(negedge clk);
    while (cmd_status[0]) begin n++; @(negedge clk); end
    check("R3 busy length", 32'(n), 32'(BC));
    check("R12 pgood early", 32'(slot_pgood[0]), 32'h0);
    repeat (PD) @(negedge clk);
    check("R12 pgood after delay", 32'(slot_pgood[0]), 32'h1);

    issue(8'h3A, 8'd2, "R2 enable+blink+off");
    issue(8'h14, 8'd1, "R2 indicators only");
    issue(8'h02, 8'd0, "R4 slot zero");
    issue(8'h02, 8'd5, "R4 slot too high");
    issue(8'h4C, 8'd0, "R4 reserved 4C");
    issue(8'h80, 8'd0, "R4 reserved 80");

    wait_idle();
    latch_open = 4'b0100;
    issue(8'h01, 8'd3, "R5 latch blocks power");
    issue(8'h13, 8'd3, "R5 disable allowed");
    issue(8'h49, 8'd0, "R5 latch blocks all-enable");
    wait_idle();
    latch_open = '0;

    issue(8'h43, 8'd0, "R6 mode A");
    issue(8'h5B, 8'd0, "R6 mode B");
    issue(8'h46, 8'd0, "R6 reserved A");
    issue(8'h5F, 8'd0, "R6 reserved B");
    issue(8'h48, 8'd0, "R7 all power-only");
    issue(8'h49, 8'd0, "R7 all enable");
    issue(8'hC5, 8'd0, "R8 vendor");

    // R12 pgood drop
    issue(8'h03, 8'd1, "R12 disable slot1");
    wait_idle();
    @(negedge clk);
    check("R12 pgood drop", 32'(slot_pgood[0]), 32'h0);

    // R3 write while busy ignored
    issue(8'h10, 8'd2, "R3 first command");
    cmd_data = {8'd4, 8'h03};
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    wait_idle();
    @(negedge clk);
    check("R3 ignored write", 32'(slot_state[7:6]), 32'(m_st[3]));
    check("R3 no retrigger", 32'(cmd_status[0]), 32'h0);

    // R9 / R11 event and interrupt
    check("R9 detected set", 32'(ctl_rdata[16]), 32'h1);
    check("R11 masked irq", 32'(cmd_irq), 32'h0);
    ctl_write(32'h0);
    check("R11 irq unmasked", 32'(cmd_irq), 32'h1);
    check("R10 masks written", 32'(ctl_rdata[3:0]), 32'h0);
    ctl_write(32'h0001_0004);
    check("R9 W1C clears", 32'(ctl_rdata[16]), 32'h0);
    check("R11 cmd mask", 32'(cmd_irq), 32'h0);
    ctl_write(32'h0);
    issue(8'hC0, 8'd0, "R8 vendor C0");
    wait_idle();
    check("R11 irq on completion", 32'(cmd_irq), 32'h1);
    ctl_write(32'h1);
    check("R11 global mask", 32'(cmd_irq), 32'h0);

    // R9 completion and clear in the same cycle
    issue(8'hC1, 8'd0, "R9 collision command");
    repeat (BC - 1) @(negedge clk);
    ctl_wdata = 32'h0001_0000;
    ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
    check("R9 set wins over clear", 32'(ctl_rdata[16]), 32'h1);
    ctl_write(32'h0001_0000);
    check("R9 clear alone", 32'(ctl_rdata[16]), 32'h0);

    // R9 error bits cleared on next accept
    issue(8'h90, 8'd0, "R4 reserved 90");
    wait_idle();
    issue(8'hC2, 8'd0, "R8 vendor C2");
    check("R9 err cleared on accept", 32'(cmd_status), 32'h1);

    wait_idle();
    repeat (3) @(negedge clk);
    check("R3 scoreboard drained", 32'(sb.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule